// File: doc/BRIEF.md
# APB Peripheral Slot Decoder with Fault Interrupt

This block sits between an AHB-to-APB bridge and a group of I/O peripherals on a 32-bit APB bus. It decodes the address of each transfer and selects at most one peripheral slot. Each slot owns an aligned 4 KB region inside a 64 KB window. Slots 0 to 3 hold 32-bit registers: timers, watchdog, system control and boot ROM. Slot 4 is a GPIO block that accepts byte, halfword and word lanes. Slot 5 is a 16-bit serial-peripheral slot and slot 6 is an 8-bit serial-port slot. Region 7 holds the decoder's own status register.

The decoder generates the bus ready for every transfer itself. Reads stall for a fixed number of wait states and writes complete without any. Data bits above a slot's width are zeroed in both directions. Byte strobes reach the slot unchanged, so an access type a slot does not support is neither blocked nor reported.

A transfer to an address with no target still completes through the decoder's own ready. It selects no slot and sets a sticky fast-interrupt flag, which software clears by writing 1 to bit 0 of the status register.

Top module: `apb_io_decoder`

## Requirements
- R1: While `psel` is high, `slotSel` has bit n set when `paddr[31:16]` equals the window base and `paddr[15:12]` equals n, for n in 0..6. Every other address leaves `slotSel` all zero. With `psel` low, `slotSel` is zero.
- R2: A read holds `pready` low for the first 2 cycles of the access phase and raises it in the third.
- R3: A write raises `pready` in the first cycle of the access phase.
- R4: Slots 0 to 4 return all 32 bits of their read data. The GPIO slot (4) receives `pstrb` and the full write word for any lane pattern: single bytes, either halfword, or the whole word.
- R5: For slot 5, `prdata[31:16]` reads 0 and `slotWdata[31:16]` is driven 0.
- R6: For slot 6, `prdata[31:8]` reads 0 and `slotWdata[31:8]` is driven 0.
- R7: An access to an unmapped address completes with the normal ready timing. `faultIrq` is high from the cycle after completion and stays high until it is cleared.
- R8: A read from an unmapped address returns 0. A write to an unmapped address changes no state: a data value of 1 does not clear `faultIrq`.
- R9: Region 7 is the status register. A read returns `faultIrq` in bit 0 and zeros above it. A write with bit 0 set clears the flag in the next cycle. A write with bit 0 clear leaves it unchanged.
- R10: An unsupported strobe pattern, such as a byte write to slot 0, still selects the slot, forwards `pstrb` unchanged and completes normally.
- R11: After reset, `faultIrq`, `pready` and `slotSel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Transfer targets this I/O bus |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 32 | Byte address |
| pwdata | input | 32 | Write data from bridge |
| pstrb | input | 4 | Byte lane strobes from bridge |
| prdata | output | 32 | Read data to bridge |
| pready | output | 1 | Transfer completion |
| slotSel | output | 7 | One select per peripheral slot |
| slotWdata | output | 32 | Width-masked write data to slots |
| slotStrb | output | 4 | Byte strobes forwarded to slots |
| slotRdata | input | 224 | Read data from slots, slot n in bits 32n+31..32n |
| faultIrq | output | 1 | Sticky fast-interrupt request for unmapped access |

## Verification
The assertions assume the bridge follows the APB protocol. A setup cycle with `psel` high and `penable` low comes first. The access phase follows it, and `paddr`, `pwrite` and `pwdata` stay stable until `pready` is seen. The bench meets this by driving every transfer through one task that holds all request signals from the setup cycle until completion. It drops `psel` and `penable` for a cycle between transfers. Random addresses are drawn across all sixteen regions of the window and from addresses outside it. Directed cases cover every slot, every lane pattern and each way the fault flag is set or cleared.

// File: rtl/apb_io_dec_pkg.sv
package apb_io_dec_pkg;
  localparam int DATA_W      = 32;
  localparam int STRB_W      = DATA_W / 8;
  localparam int SLOT_COUNT  = 7;
  localparam int STATUS_SLOT = 7;
  localparam int REGION_W    = 12;
  localparam int INDEX_W     = 4;
  localparam int WIN_LSB     = REGION_W + INDEX_W;

  // strobes from control to datapath
  typedef struct packed {
    logic [SLOT_COUNT-1:0] hit;
    logic                  statusHit;
    logic                  unmapped;
    logic                  done;
    logic                  wr;
  } decStrobe_t;

  function automatic int slotWidth(input int slot);
    case (slot)
      5:       return 16;
      6:       return 8;
      default: return DATA_W;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] widthMask(input int w);
    if (w >= DATA_W) return '1;
    return (DATA_W'(1) << w) - DATA_W'(1);
  endfunction
endpackage

// File: rtl/apb_io_dec_ctrl.sv
module apb_io_dec_ctrl
  import apb_io_dec_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR  = 32'h4000_0000,
  parameter int          READ_WAIT  = 2,
  parameter int          WRITE_WAIT = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [31:REGION_W]  addrHi,
  output logic                pready,
  output logic [SLOT_COUNT-1:0] slotSel,
  output decStrobe_t          strb
);
  localparam int WAIT_MAX = (READ_WAIT > WRITE_WAIT) ? READ_WAIT : WRITE_WAIT;
  localparam int CNT_W    = $clog2(WAIT_MAX + 2);

  logic               inWin;
  logic [INDEX_W-1:0] idx;
  logic [SLOT_COUNT-1:0] hitVec;
  logic               statusHit;
  logic               accessPh;
  logic [CNT_W-1:0]   waitCnt;
  logic [CNT_W-1:0]   waitGoal;

  assign inWin     = (addrHi[31:WIN_LSB] == BASE_ADDR[31:WIN_LSB]);
  assign idx       = addrHi[WIN_LSB-1:REGION_W];
  assign statusHit = inWin && (idx == INDEX_W'(STATUS_SLOT));

  for (genvar i = 0; i < SLOT_COUNT; i++) begin : gHit
    assign hitVec[i] = inWin && (idx == INDEX_W'(i));
  end

  assign accessPh = psel && penable;
  assign waitGoal = pwrite ? CNT_W'(WRITE_WAIT) : CNT_W'(READ_WAIT);
  assign pready   = accessPh && (waitCnt == waitGoal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   waitCnt <= '0;
    else if (accessPh && !pready) waitCnt <= waitCnt + CNT_W'(1);
    else                          waitCnt <= '0;
  end

  assign slotSel = psel ? hitVec : '0;

  always_comb begin
    strb.hit       = hitVec;
    strb.statusHit = statusHit;
    strb.unmapped  = !(|hitVec) && !statusHit;
    strb.done      = accessPh && pready;
    strb.wr        = pwrite;
  end
endmodule

// File: rtl/apb_io_dec_datapath.sv
module apb_io_dec_datapath
  import apb_io_dec_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  decStrobe_t                   strb,
  input  logic [DATA_W-1:0]            pwdata,
  input  logic [SLOT_COUNT*DATA_W-1:0] slotRdata,
  output logic [DATA_W-1:0]            prdata,
  output logic [DATA_W-1:0]            slotWdata,
  output logic                         faultIrq
);
  logic [SLOT_COUNT-1:0][DATA_W-1:0] maskedRd;
  logic [SLOT_COUNT-1:0][DATA_W-1:0] laneMask;
  logic [DATA_W-1:0] muxRd;
  logic [DATA_W-1:0] wrMask;
  logic              faultFlag;

  for (genvar s = 0; s < SLOT_COUNT; s++) begin : gSlot
    localparam logic [DATA_W-1:0] MASK = widthMask(slotWidth(s));
    assign laneMask[s] = MASK;
    assign maskedRd[s] = slotRdata[s*DATA_W +: DATA_W] & MASK;
  end

  always_comb begin
    muxRd  = '0;
    wrMask = '0;
    for (int s = 0; s < SLOT_COUNT; s++) begin
      if (strb.hit[s]) begin
        muxRd  = muxRd  | maskedRd[s];
        wrMask = wrMask | laneMask[s];
      end
    end
    if (strb.statusHit) muxRd = {{(DATA_W-1){1'b0}}, faultFlag};
  end

  assign prdata    = muxRd;
  assign slotWdata = pwdata & wrMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                              faultFlag <= 1'b0;
    else if (strb.done && strb.unmapped)                    faultFlag <= 1'b1;
    else if (strb.done && strb.statusHit && strb.wr && pwdata[0]) faultFlag <= 1'b0;
  end

  assign faultIrq = faultFlag;
endmodule

// File: rtl/apb_io_decoder.sv
module apb_io_decoder
  import apb_io_dec_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR  = 32'h4000_0000,
  parameter int          READ_WAIT  = 2,
  parameter int          WRITE_WAIT = 0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         psel,
  input  logic                         penable,
  input  logic                         pwrite,
  input  logic [31:0]                  paddr,
  input  logic [DATA_W-1:0]            pwdata,
  input  logic [STRB_W-1:0]            pstrb,
  output logic [DATA_W-1:0]            prdata,
  output logic                         pready,
  output logic [SLOT_COUNT-1:0]        slotSel,
  output logic [DATA_W-1:0]            slotWdata,
  output logic [STRB_W-1:0]            slotStrb,
  input  logic [SLOT_COUNT*DATA_W-1:0] slotRdata,
  output logic                         faultIrq
);
  decStrobe_t decStrb;
  logic       unusedOffset;

  assign unusedOffset = ^paddr[REGION_W-1:0];
  assign slotStrb     = pstrb;

  apb_io_dec_ctrl #(
    .BASE_ADDR (BASE_ADDR),
    .READ_WAIT (READ_WAIT),
    .WRITE_WAIT(WRITE_WAIT)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .psel   (psel),
    .penable(penable),
    .pwrite (pwrite),
    .addrHi (paddr[31:REGION_W]),
    .pready (pready),
    .slotSel(slotSel),
    .strb   (decStrb)
  );

  apb_io_dec_datapath uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (decStrb),
    .pwdata   (pwdata),
    .slotRdata(slotRdata),
    .prdata   (prdata),
    .slotWdata(slotWdata),
    .faultIrq (faultIrq)
  );
endmodule

// File: rtl/apb_io_dec_chk.sv
module apb_io_dec_chk
  import apb_io_dec_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR  = 32'h4000_0000,
  parameter int          READ_WAIT  = 2,
  parameter int          WRITE_WAIT = 0
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  psel,
  input logic                  penable,
  input logic                  pwrite,
  input logic [31:0]           paddr,
  input logic [DATA_W-1:0]     pwdata,
  input logic [DATA_W-1:0]     prdata,
  input logic                  pready,
  input logic [SLOT_COUNT-1:0] slotSel,
  input logic                  faultIrq
);
  logic inWin;
  logic [INDEX_W-1:0] idx;
  logic unmappedAddr;
  logic doneNow;
  logic clearNow;

  assign inWin        = (paddr[31:WIN_LSB] == BASE_ADDR[31:WIN_LSB]);
  assign idx          = paddr[WIN_LSB-1:REGION_W];
  assign unmappedAddr = !inWin || (idx > INDEX_W'(STATUS_SLOT));
  assign doneNow      = psel && penable && pready;
  assign clearNow     = doneNow && pwrite && inWin && (idx == INDEX_W'(STATUS_SLOT)) && pwdata[0];

  a_r1_sel_onehot: assert property (@(posedge clk) disable iff (!rstN) $onehot0(slotSel));
  a_r1_sel_idle: assert property (@(posedge clk) disable iff (!rstN) !psel |-> (slotSel == '0));
  a_r2_read_stall: assert property (@(posedge clk) disable iff (!rstN)
    (psel && !penable && !pwrite && READ_WAIT > 0) |=> !pready);
  a_r3_write_fast: assert property (@(posedge clk) disable iff (!rstN)
    (psel && !penable && pwrite && WRITE_WAIT == 0) |=> (!penable || pready));
  a_r5_spi_width: assert property (@(posedge clk) disable iff (!rstN) slotSel[5] |-> (prdata[31:16] == '0));
  a_r6_uart_width: assert property (@(posedge clk) disable iff (!rstN) slotSel[6] |-> (prdata[31:8] == '0));
  a_r7_fault_set: assert property (@(posedge clk) disable iff (!rstN) (doneNow && unmappedAddr) |=> faultIrq);
  a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rstN) (faultIrq && !clearNow) |=> faultIrq);
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (doneNow && !pwrite && unmappedAddr) |-> (prdata == '0));
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN) clearNow |=> !faultIrq);
  a_r11_ready_access: assert property (@(posedge clk) disable iff (!rstN) pready |-> (psel && penable));
endmodule

bind apb_io_decoder apb_io_dec_chk #(
  .BASE_ADDR (BASE_ADDR),
  .READ_WAIT (READ_WAIT),
  .WRITE_WAIT(WRITE_WAIT)
) uChk (.*);

// File: tb/tb_apb_io_decoder.sv
module tb_apb_io_decoder;
  localparam logic [31:0] BASE = 32'h4000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [31:0] paddr = '0, pwdata = '0;
  logic [3:0]  pstrb = '0;
  logic [31:0] prdata, slotWdata;
  logic        pready, faultIrq;
  logic [6:0]  slotSel;
  logic [3:0]  slotStrb;
  logic [31:0] slotMem [7];
  logic [223:0] slotRdata;

  int checks = 0;
  int errors = 0;
  bit flagModel = 1'b0;

  always #4 clk = ~clk;

  always_comb
    for (int s = 0; s < 7; s++) slotRdata[s*32 +: 32] = slotMem[s];

  apb_io_decoder dut (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata), .pready(pready),
    .slotSel(slotSel), .slotWdata(slotWdata), .slotStrb(slotStrb),
    .slotRdata(slotRdata), .faultIrq(faultIrq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // -1 unmapped, 0..6 slot, 7 status register
  function automatic int expSlot(input logic [31:0] a);
    if (a[31:16] != BASE[31:16]) return -1;
    if (a[15:12] > 4'd7) return -1;
    return int'(a[15:12]);
  endfunction

  function automatic logic [31:0] expMask(input int s);
    if (s == 5) return 32'h0000_FFFF;
    if (s == 6) return 32'h0000_00FF;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic string widthReq(input int s);
    if (s == 5) return "R5";
    if (s == 6) return "R6";
    return "R4";
  endfunction

  task automatic access(input logic [31:0] a, input bit wr, input logic [31:0] wd, input logic [3:0] st);
    int s;
    int waits;
    logic [31:0] rd;
    logic [6:0] expSel;
    s = expSlot(a);
    @(negedge clk);
    paddr = a; pwrite = wr; pwdata = wd; pstrb = st; psel = 1'b1; penable = 1'b0;
    #1;
    expSel = (s >= 0 && s < 7) ? 7'(1 << s) : 7'd0;
    check(slotSel == expSel, "R1", 32'(slotSel), 32'(expSel));
    if (wr && s >= 0 && s < 7) begin
      check(slotWdata == (wd & expMask(s)), widthReq(s), slotWdata, wd & expMask(s));
      check(slotStrb == st, (s == 0) ? "R10" : "R4", 32'(slotStrb), 32'(st));
    end
    @(negedge clk);
    penable = 1'b1;
    waits = 0;
    rd = '0;
    forever begin
      #1;
      if (pready) begin
        rd = prdata;
        break;
      end
      waits++;
      if (waits > 10) break;
      @(negedge clk);
    end
    check(waits == (wr ? 0 : 2), wr ? "R3" : "R2", 32'(waits), wr ? 32'd0 : 32'd2);
    if (!wr) begin
      if (s < 0)       check(rd == 32'd0, "R8", rd, 32'd0);
      else if (s == 7) check(rd == {31'd0, flagModel}, "R9", rd, {31'd0, flagModel});
      else             check(rd == (slotMem[s] & expMask(s)), widthReq(s), rd, slotMem[s] & expMask(s));
    end
    if (s < 0) flagModel = 1'b1;
    else if (s == 7 && wr && wd[0]) flagModel = 1'b0;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
    #1;
    check(faultIrq == flagModel, (s < 0) ? "R7" : "R9", 32'(faultIrq), 32'(flagModel));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < 7; s++) slotMem[s] = $urandom();
    slotMem[5] = 32'hABCD_1234;
    slotMem[6] = 32'h5A5A_5AC3;
    repeat (3) @(negedge clk);
    check(faultIrq == 1'b0 && pready == 1'b0 && slotSel == '0, "R11",
          {faultIrq, pready, slotSel}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(faultIrq == 1'b0 && pready == 1'b0 && slotSel == '0, "R11",
          {faultIrq, pready, slotSel}, 32'd0);

    // every slot and the status register
    for (int s = 0; s < 8; s++) access(BASE | (s << 12) | 32'h10, 1'b0, '0, 4'h0);
    // GPIO lane patterns
    foreach (slotMem[k]) if (k == 0) begin end
    access(BASE | 32'h4000, 1'b1, 32'h1122_3344, 4'b0001);
    access(BASE | 32'h4001, 1'b1, 32'h1122_3344, 4'b0010);
    access(BASE | 32'h4002, 1'b1, 32'h1122_3344, 4'b0100);
    access(BASE | 32'h4003, 1'b1, 32'h1122_3344, 4'b1000);
    access(BASE | 32'h4000, 1'b1, 32'h1122_3344, 4'b0011);
    access(BASE | 32'h4002, 1'b1, 32'h1122_3344, 4'b1100);
    access(BASE | 32'h4000, 1'b1, 32'h1122_3344, 4'b1111);
    // narrow slots write masking
    access(BASE | 32'h5000, 1'b1, 32'hFFFF_FFFF, 4'b1111);
    access(BASE | 32'h6000, 1'b1, 32'hFFFF_FFFF, 4'b1111);
    // unsupported byte write to timer slot
    access(BASE | 32'h0008, 1'b1, 32'hDEAD_BEEF, 4'b0001);
    // unmapped: outside window, then inside window above status
    access(32'h8000_0100, 1'b0, '0, 4'h0);
    access(BASE | 32'h9000, 1'b0, '0, 4'h0);
    // unmapped write with bit 0 set must not clear
    access(32'h1234_7000, 1'b1, 32'h0000_0001, 4'hF);
    access(BASE | 32'h7000, 1'b0, '0, 4'h0);
    // status write 0 keeps, write 1 clears
    access(BASE | 32'h7000, 1'b1, 32'h0000_0000, 4'hF);
    access(BASE | 32'h7000, 1'b1, 32'h0000_0001, 4'hF);
    access(BASE | 32'h7000, 1'b0, '0, 4'h0);

    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      int r;
      r = int'($urandom() % 20);
      if (r < 16) a = BASE | (32'(r) << 12) | ($urandom() & 32'h0000_0FFC);
      else begin
        a = $urandom();
        if (a[31:16] == BASE[31:16]) a[31] = ~a[31];
      end
      if (n % 37 == 0) slotMem[n % 7] = $urandom();
      access(a, 1'($urandom()), $urandom(), 4'($urandom()));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule